// File: doc/BRIEF.md
# Coprocessor Instruction Dispatch Controller

This block sits beside a processor core's execute stage and takes over an instruction the core cannot execute itself. When the core traps such an instruction, the controller latches the 32-bit word, takes the values of its two source registers (forcing zero for register index 0), and offers all three to a coprocessor bus with a valid flag. Two coprocessor units can listen: one inside the core and one on an external port. Their wait and ready lines are merged by OR. When both finish in the same cycle, the external unit's response is the one taken.

On completion the controller drops valid and pulses a resume signal so the core goes back to fetching. If the finishing unit raised its write flag and the destination field is not register 0, it also issues a one-cycle register write request. If no unit either finishes or raises wait within a 16-cycle claim window, the controller drops valid and pulses an illegal-instruction exception. A unit that holds wait keeps the window from running for as long as it needs.

The controller is a two-state machine. In `S_IDLE`, valid is low; the transition *accept* (a trap request) leads to `S_ACTIVE`. In `S_ACTIVE`, valid is high. The transition *complete* (merged ready) and the transition *expire* (window used up with no ready and no wait) both lead back to `S_IDLE`. *Complete* takes priority over *expire*.

Top module: `copro_dispatch`

## Requirements
- R1: A `trap_req` seen while valid is low is accepted at that clock edge. From the next cycle `disp_valid` is 1, `disp_insn` holds the trapped word, and `disp_opa`/`disp_opb` hold `trap_src_a`/`trap_src_b`.
- R2: An operand whose source index is 0 is driven as 0 regardless of the value supplied. The rs1 index is `insn[19:15]` and feeds `disp_opa`; the rs2 index is `insn[24:20]` and feeds `disp_opb`.
- R3: While `disp_valid` is 1, `disp_insn`, `disp_opa` and `disp_opb` do not change, and a `trap_req` arriving then is ignored.
- R4: A ready from either unit during a valid cycle makes `disp_valid` 0 in the next cycle. In that same next cycle `resume_fetch` is 1 for exactly one cycle.
- R5: At completion, `wb_en` is 1 in the `resume_fetch` cycle only if the selected write flag was 1 and the destination index `insn[11:7]` is not 0. In that cycle `wb_idx` equals `insn[11:7]` and `wb_data` equals the selected result.
- R6: Wait and ready from the internal and external units are combined by OR. When the external unit is ready, its write flag and result are selected; otherwise the internal unit's are used.
- R7: After 16 consecutive valid cycles with no ready and no wait, `illegal_trap` is 1 for one cycle in the 17th cycle. In that cycle `disp_valid` is 0 and `resume_fetch` is 0.
- R8: Any cycle with wait high restarts the claim window. A full 16 wait-free cycles are then needed before the exception, and wait held for any length keeps the operation alive.
- R9: A ready in the 16th wait-free valid cycle completes the operation normally, and no exception is raised.
- R10: While `rst_n` is 0 and after its release, `disp_valid`, `wb_en`, `resume_fetch` and `illegal_trap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Core has trapped an unsupported instruction |
| trap_insn | input | 32 | Trapped instruction word |
| trap_src_a | input | 32 | Register file value for the rs1 index |
| trap_src_b | input | 32 | Register file value for the rs2 index |
| disp_valid | output | 1 | Instruction offered to the coprocessor bus |
| disp_insn | output | 32 | Offered instruction word |
| disp_opa | output | 32 | First operand |
| disp_opb | output | 32 | Second operand |
| int_wr | input | 1 | Internal unit requests a register write |
| int_result | input | 32 | Internal unit result |
| int_wait | input | 1 | Internal unit has claimed and is busy |
| int_ready | input | 1 | Internal unit has finished |
| ext_wr | input | 1 | External unit requests a register write |
| ext_result | input | 32 | External unit result |
| ext_wait | input | 1 | External unit has claimed and is busy |
| ext_ready | input | 1 | External unit has finished |
| wb_en | output | 1 | Register write request, one cycle |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Value to write |
| resume_fetch | output | 1 | Operation completed, core resumes fetching |
| illegal_trap | output | 1 | No unit claimed the instruction, one cycle |

## Verification
The checker assumes that units raise ready and wait only while `disp_valid` is high. It also assumes that ready lasts a single cycle, because the block treats any ready seen in `S_IDLE` as meaningless. The stimulus places every ready pulse inside a chosen valid cycle and opens and closes every wait interval within the valid window. Trap requests are made either while valid is low or, in the one test of R3, deliberately during an active operation and withdrawn before it completes. The window checks count wait-free valid cycles from the ports rather than reading the internal counter.

// File: rtl/copro_pkg.sv
package copro_pkg;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_ACTIVE = 1'b1
    } disp_state_e;

    // Instruction field positions used by the controller
    localparam int unsigned IDX_W   = 5;
    localparam int unsigned RD_LSB  = 7;
    localparam int unsigned RS1_LSB = 15;
    localparam int unsigned RS2_LSB = 20;

endpackage

// File: rtl/copro_operand_stage.sv
module copro_operand_stage
    import copro_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [XLEN-1:0]        insn_in,
    input  logic [1:0][XLEN-1:0]   src_in,
    output logic [XLEN-1:0]        insn_q,
    output logic [1:0][XLEN-1:0]   opnd_q
);

    logic [XLEN-1:0] opnd_r [2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insn_q <= '0;
        end else if (load) begin
            insn_q <= insn_in;
        end
    end

    // One latch per source operand; index 0 reads as zero (R2)
    for (genvar g = 0; g < 2; g++) begin : g_opnd
        localparam int unsigned LSB = (g == 0) ? RS1_LSB : RS2_LSB;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                opnd_r[g] <= '0;
            end else if (load) begin
                opnd_r[g] <= (insn_in[LSB +: IDX_W] == '0) ? '0 : src_in[g];
            end
        end
        assign opnd_q[g] = opnd_r[g];
    end

endmodule

// File: rtl/copro_claim_timer.sv
module copro_claim_timer #(
    parameter int unsigned CLAIM_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hold,
    output logic expired
);

    localparam int unsigned CNT_W = (CLAIM_CYCLES > 2) ? $clog2(CLAIM_CYCLES) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CLAIM_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (!run || hold) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/copro_resp_merge.sv
module copro_resp_merge #(
    parameter int unsigned XLEN    = 32,
    parameter bit          USE_INT = 1'b1,
    parameter bit          USE_EXT = 1'b1
) (
    input  logic            int_wr,
    input  logic [XLEN-1:0] int_result,
    input  logic            int_wait,
    input  logic            int_ready,
    input  logic            ext_wr,
    input  logic [XLEN-1:0] ext_result,
    input  logic            ext_wait,
    input  logic            ext_ready,
    output logic            any_wait,
    output logic            any_ready,
    output logic            sel_wr,
    output logic [XLEN-1:0] sel_data
);

    logic            i_rdy, i_wt, i_wr;
    logic [XLEN-1:0] i_dat;
    logic            e_rdy, e_wt, e_wr;
    logic [XLEN-1:0] e_dat;

    if (USE_INT) begin : g_int_on
        assign i_rdy = int_ready;
        assign i_wt  = int_wait;
        assign i_wr  = int_wr;
        assign i_dat = int_result;
    end else begin : g_int_off
        assign i_rdy = 1'b0;
        assign i_wt  = 1'b0;
        assign i_wr  = 1'b0;
        assign i_dat = '0;
    end

    if (USE_EXT) begin : g_ext_on
        assign e_rdy = ext_ready;
        assign e_wt  = ext_wait;
        assign e_wr  = ext_wr;
        assign e_dat = ext_result;
    end else begin : g_ext_off
        assign e_rdy = 1'b0;
        assign e_wt  = 1'b0;
        assign e_wr  = 1'b0;
        assign e_dat = '0;
    end

    always_comb begin
        any_wait  = i_wt | e_wt;
        any_ready = i_rdy | e_rdy;
        if (e_rdy) begin
            sel_wr   = e_wr;
            sel_data = e_dat;
        end else begin
            sel_wr   = i_wr & i_rdy;
            sel_data = i_dat;
        end
    end

endmodule

// File: rtl/copro_dispatch.sv
module copro_dispatch
    import copro_pkg::*;
#(
    parameter int unsigned XLEN         = 32,
    parameter int unsigned CLAIM_CYCLES = 16,
    parameter bit          USE_INT      = 1'b1,
    parameter bit          USE_EXT      = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req,
    input  logic [XLEN-1:0]  trap_insn,
    input  logic [XLEN-1:0]  trap_src_a,
    input  logic [XLEN-1:0]  trap_src_b,
    output logic             disp_valid,
    output logic [XLEN-1:0]  disp_insn,
    output logic [XLEN-1:0]  disp_opa,
    output logic [XLEN-1:0]  disp_opb,
    input  logic             int_wr,
    input  logic [XLEN-1:0]  int_result,
    input  logic             int_wait,
    input  logic             int_ready,
    input  logic             ext_wr,
    input  logic [XLEN-1:0]  ext_result,
    input  logic             ext_wait,
    input  logic             ext_ready,
    output logic             wb_en,
    output logic [IDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]  wb_data,
    output logic             resume_fetch,
    output logic             illegal_trap
);

    disp_state_e state_q, state_d;

    logic            accept, finish, expire;
    logic            any_wait, any_ready, sel_wr, expired;
    logic [XLEN-1:0] sel_data;
    logic [1:0][XLEN-1:0] src_pair, opnd_pair;
    logic [IDX_W-1:0] rd_idx;

    assign src_pair[0] = trap_src_a;
    assign src_pair[1] = trap_src_b;

    copro_operand_stage #(.XLEN(XLEN)) u_opnd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .insn_in (trap_insn),
        .src_in  (src_pair),
        .insn_q  (disp_insn),
        .opnd_q  (opnd_pair)
    );

    assign disp_opa = opnd_pair[0];
    assign disp_opb = opnd_pair[1];
    assign rd_idx   = disp_insn[RD_LSB +: IDX_W];

    copro_resp_merge #(.XLEN(XLEN), .USE_INT(USE_INT), .USE_EXT(USE_EXT)) u_merge (
        .int_wr     (int_wr),
        .int_result (int_result),
        .int_wait   (int_wait),
        .int_ready  (int_ready),
        .ext_wr     (ext_wr),
        .ext_result (ext_result),
        .ext_wait   (ext_wait),
        .ext_ready  (ext_ready),
        .any_wait   (any_wait),
        .any_ready  (any_ready),
        .sel_wr     (sel_wr),
        .sel_data   (sel_data)
    );

    copro_claim_timer #(.CLAIM_CYCLES(CLAIM_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (disp_valid),
        .hold    (any_wait),
        .expired (expired)
    );

    // Transition conditions
    assign disp_valid = (state_q == S_ACTIVE);
    assign accept     = (state_q == S_IDLE) && trap_req;
    assign finish     = disp_valid && any_ready;
    assign expire     = disp_valid && !any_ready && !any_wait && expired;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (trap_req) state_d = S_ACTIVE;
            S_ACTIVE: if (any_ready || (!any_wait && expired)) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_fetch <= 1'b0;
            illegal_trap <= 1'b0;
            wb_en        <= 1'b0;
            wb_idx       <= '0;
            wb_data      <= '0;
        end else begin
            resume_fetch <= finish;
            illegal_trap <= expire;
            wb_en        <= finish && sel_wr && (rd_idx != '0);
            if (finish) begin
                wb_idx  <= rd_idx;
                wb_data <= sel_data;
            end
        end
    end

endmodule

// File: rtl/copro_dispatch_chk.sv
module copro_dispatch_chk #(
    parameter int unsigned XLEN         = 32,
    parameter int unsigned CLAIM_CYCLES = 16,
    parameter bit          USE_INT      = 1'b1,
    parameter bit          USE_EXT      = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_req,
    input logic            disp_valid,
    input logic [XLEN-1:0] disp_insn,
    input logic [XLEN-1:0] disp_opa,
    input logic [XLEN-1:0] disp_opb,
    input logic            int_wait,
    input logic            int_ready,
    input logic            ext_wait,
    input logic            ext_ready,
    input logic            wb_en,
    input logic [4:0]      wb_idx,
    input logic            resume_fetch,
    input logic            illegal_trap
);

    localparam int unsigned RW = $clog2(CLAIM_CYCLES + 1) + 1;
    localparam logic [RW-1:0] LIMIT = RW'(CLAIM_CYCLES);

    logic rdy, wt;
    assign rdy = (USE_INT && int_ready) || (USE_EXT && ext_ready);
    assign wt  = (USE_INT && int_wait)  || (USE_EXT && ext_wait);

    // Consecutive wait-free valid cycles, counted from the ports
    logic [RW-1:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (disp_valid && !wt) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_valid && trap_req) |=> disp_valid);

    a_r3_stable: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> ($stable(disp_insn) && $stable(disp_opa) && $stable(disp_opb)));

    a_r4_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && rdy) |=> (!disp_valid && resume_fetch));

    a_r4_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resume_fetch |=> !resume_fetch);

    a_r5_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (resume_fetch && wb_idx != 5'd0));

    a_r7_exc_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_trap |-> (!disp_valid && !resume_fetch));

    a_r7_window: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_trap |-> (run_len == LIMIT));

    a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (run_len < LIMIT));

    a_r9_ready_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && rdy) |=> !illegal_trap);

endmodule

bind copro_dispatch copro_dispatch_chk #(
    .XLEN(XLEN), .CLAIM_CYCLES(CLAIM_CYCLES), .USE_INT(USE_INT), .USE_EXT(USE_EXT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trap_req     (trap_req),
    .disp_valid   (disp_valid),
    .disp_insn    (disp_insn),
    .disp_opa     (disp_opa),
    .disp_opb     (disp_opb),
    .int_wait     (int_wait),
    .int_ready    (int_ready),
    .ext_wait     (ext_wait),
    .ext_ready    (ext_ready),
    .wb_en        (wb_en),
    .wb_idx       (wb_idx),
    .resume_fetch (resume_fetch),
    .illegal_trap (illegal_trap)
);

// File: tb/tb_copro_dispatch.sv
module tb_copro_dispatch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic [31:0] trap_insn = '0, trap_src_a = '0, trap_src_b = '0;
    logic        disp_valid;
    logic [31:0] disp_insn, disp_opa, disp_opb;
    logic        int_wr = 1'b0, int_wait = 1'b0, int_ready = 1'b0;
    logic [31:0] int_result = '0;
    logic        ext_wr = 1'b0, ext_wait = 1'b0, ext_ready = 1'b0;
    logic [31:0] ext_result = '0;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;
    logic        resume_fetch, illegal_trap;

    always #2 clk = ~clk;

    copro_dispatch dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_insn(trap_insn),
        .trap_src_a(trap_src_a), .trap_src_b(trap_src_b),
        .disp_valid(disp_valid), .disp_insn(disp_insn), .disp_opa(disp_opa), .disp_opb(disp_opb),
        .int_wr(int_wr), .int_result(int_result), .int_wait(int_wait), .int_ready(int_ready),
        .ext_wr(ext_wr), .ext_result(ext_result), .ext_wait(ext_wait), .ext_ready(ext_ready),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .resume_fetch(resume_fetch), .illegal_trap(illegal_trap)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          is_exc;
        bit          wen;
        logic [4:0]  idx;
        logic [31:0] data;
        int          len;
        string       req;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2);
        return {7'h01, rs2, rs1, 3'b000, rd, 7'h0B};
    endfunction

    task automatic push(input bit is_exc, input bit wen, input logic [4:0] idx,
                        input logic [31:0] data, input int len, input string req);
        exp_t e;
        e.is_exc = is_exc; e.wen = wen; e.idx = idx; e.data = data; e.len = len; e.req = req;
        sb.push_back(e);
    endtask

    // Driver: ends at the negedge inside valid cycle 1
    task automatic issue(input logic [31:0] insn, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        trap_req = 1'b1; trap_insn = insn; trap_src_a = a; trap_src_b = b;
        @(negedge clk);
        trap_req = 1'b0;
    endtask

    // Ready pulse in valid cycle k (called from the negedge of cycle 1)
    task automatic respond(input int k, input bit do_i, input bit wr_i, input logic [31:0] ri,
                           input bit do_e, input bit wr_e, input logic [31:0] re);
        repeat (k - 1) @(negedge clk);
        int_ready = do_i; int_wr = wr_i; int_result = ri;
        ext_ready = do_e; ext_wr = wr_e; ext_result = re;
        @(negedge clk);
        int_ready = 1'b0; int_wr = 1'b0; ext_ready = 1'b0; ext_wr = 1'b0;
    endtask

    // Monitor: pops one expected item per completion or exception
    int vlen = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (disp_valid) vlen++;
            if (resume_fetch || illegal_trap) begin
                if (sb.size() == 0) begin
                    chk("R4", "unexpected event", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(e.req, "valid low at event", {31'd0, disp_valid}, 32'd0);
                    chk(e.req, "exception flag", {31'd0, illegal_trap}, {31'd0, e.is_exc});
                    chk(e.req, "resume flag", {31'd0, resume_fetch}, {31'd0, !e.is_exc});
                    chk(e.req, "valid length", vlen, e.len);
                    chk(e.req, "write enable", {31'd0, wb_en}, {31'd0, e.wen});
                    if (e.wen) begin
                        chk(e.req, "write index", {27'd0, wb_idx}, {27'd0, e.idx});
                        chk(e.req, "write data", wb_data, e.data);
                    end
                end
                vlen = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "valid in reset", {31'd0, disp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "valid after reset", {31'd0, disp_valid}, 32'd0);
        chk("R10", "wb_en after reset", {31'd0, wb_en}, 32'd0);
        chk("R10", "resume after reset", {31'd0, resume_fetch}, 32'd0);
        chk("R10", "exception after reset", {31'd0, illegal_trap}, 32'd0);

        // R1 R4 R5: internal unit completes in cycle 3 with a write to x5
        push(1'b0, 1'b1, 5'd5, 32'h1111_2222, 3, "R5");
        issue(mk(5'd5, 5'd3, 5'd4), 32'hAAAA_0001, 32'hBBBB_0002);
        chk("R1", "valid", {31'd0, disp_valid}, 32'd1);
        chk("R1", "insn", disp_insn, mk(5'd5, 5'd3, 5'd4));
        chk("R1", "operand a", disp_opa, 32'hAAAA_0001);
        chk("R1", "operand b", disp_opb, 32'hBBBB_0002);
        respond(3, 1'b1, 1'b1, 32'h1111_2222, 1'b0, 1'b0, 32'h0);

        // R2: zero source indexes; R5 no write flag -> no write
        push(1'b0, 1'b0, 5'd7, 32'h0, 1, "R5");
        issue(mk(5'd7, 5'd0, 5'd0), 32'hDEAD_BEEF, 32'hCAFE_F00D);
        chk("R2", "operand a from x0", disp_opa, 32'h0);
        chk("R2", "operand b from x0", disp_opb, 32'h0);
        respond(1, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h5555_5555);

        // R6: both ready, external result selected
        push(1'b0, 1'b1, 5'd9, 32'h0E0E_0E0E, 2, "R6");
        issue(mk(5'd9, 5'd1, 5'd0), 32'h1, 32'h2);
        chk("R2", "operand b zeroed, a kept", disp_opa ^ disp_opb, 32'h1);
        respond(2, 1'b1, 1'b1, 32'h1A1A_1A1A, 1'b1, 1'b1, 32'h0E0E_0E0E);

        // R6: external ready without write flag overrides internal write
        push(1'b0, 1'b0, 5'd10, 32'h0, 2, "R6");
        issue(mk(5'd10, 5'd1, 5'd2), 32'h3, 32'h4);
        respond(2, 1'b1, 1'b1, 32'h2B2B_2B2B, 1'b1, 1'b0, 32'h3C3C_3C3C);

        // R5: destination x0 suppresses the write
        push(1'b0, 1'b0, 5'd0, 32'h0, 1, "R5");
        issue(mk(5'd0, 5'd2, 5'd3), 32'h5, 32'h6);
        respond(1, 1'b1, 1'b1, 32'h7777_7777, 1'b0, 1'b0, 32'h0);

        // R7: no response -> exception in cycle 17
        push(1'b1, 1'b0, 5'd0, 32'h0, 16, "R7");
        issue(mk(5'd11, 5'd1, 5'd1), 32'h8, 32'h9);
        repeat (15) @(negedge clk);
        chk("R7", "valid still high in cycle 16", {31'd0, disp_valid}, 32'd1);
        @(negedge clk);

        // R9: ready in cycle 16 beats the timeout
        push(1'b0, 1'b1, 5'd12, 32'h1616_1616, 16, "R9");
        issue(mk(5'd12, 5'd1, 5'd1), 32'h8, 32'h9);
        respond(16, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 32'h1616_1616);

        // R8: external wait in cycles 3..42, then silence -> exception in cycle 59
        push(1'b1, 1'b0, 5'd0, 32'h0, 58, "R8");
        issue(mk(5'd13, 5'd1, 5'd1), 32'h8, 32'h9);
        repeat (2) @(negedge clk);
        ext_wait = 1'b1;
        repeat (40) @(negedge clk);
        ext_wait = 1'b0;
        repeat (16) @(negedge clk);

        // R8 R6: internal wait cycles 2..30, ready in cycle 30
        push(1'b0, 1'b1, 5'd14, 32'h3030_3030, 30, "R8");
        issue(mk(5'd14, 5'd1, 5'd1), 32'h8, 32'h9);
        @(negedge clk);
        int_wait = 1'b1;
        repeat (28) @(negedge clk);
        int_ready = 1'b1; int_wr = 1'b1; int_result = 32'h3030_3030;
        @(negedge clk);
        int_ready = 1'b0; int_wr = 1'b0; int_wait = 1'b0;

        // R3: second trap during an active operation is ignored
        push(1'b0, 1'b1, 5'd15, 32'h4444_4444, 4, "R3");
        issue(mk(5'd15, 5'd3, 5'd4), 32'h0101_0101, 32'h0202_0202);
        trap_req = 1'b1; trap_insn = mk(5'd20, 5'd21, 5'd22);
        trap_src_a = 32'hFFFF_FFFF; trap_src_b = 32'hEEEE_EEEE;
        @(negedge clk);
        chk("R3", "insn held", disp_insn, mk(5'd15, 5'd3, 5'd4));
        chk("R3", "operand a held", disp_opa, 32'h0101_0101);
        @(negedge clk);
        trap_req = 1'b0;
        chk("R3", "operand b held", disp_opb, 32'h0202_0202);
        respond(2, 1'b1, 1'b1, 32'h4444_4444, 1'b0, 1'b0, 32'h0);
        repeat (3) @(negedge clk);
        chk("R3", "no second operation", {31'd0, disp_valid}, 32'd0);

        chk("R4", "scoreboard drained", sb.size(), 32'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule